// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction Processor Core

This core runs a compact instruction set whose instructions occupy 25 bits and whose data words are 32 bits wide. Each clock edge completes one whole instruction. In that cycle the core fetches the word at the program counter from an instruction memory port. It decodes the fields, reads two of its eight general registers and computes an add, a nand or an address. It may then read or write the data memory port, and it writes back and updates the program counter. Both memories are word addressed. The data memory is read combinationally and written on the clock edge.

A two-state controller sequences the core. In `ST_RUN` every instruction retires. Decoding the stop instruction takes the transition `RUN->STOP`. `ST_STOP` keeps the program counter on the stop instruction and blocks every register and memory update. Its only exit is synchronous reset, which is the transition `STOP->RUN` and also `RUN->RUN` with all state cleared. While the controller holds `ST_RUN` and no stop instruction is decoded, it stays in `ST_RUN`.

The instruction memory and data memory sit outside the core. The surrounding system or bench preloads them through their own ports.

Top module: `wordcore_cpu`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, all eight registers and the halted flag. After reset `imem_addr` is 0 and `halted` is 0, and every register reads as zero until it is written.
- R2: The opcode is in bits 24–22, regA in bits 21–19, regB in bits 18–16 and the destination in bits 2–0. Opcode 000 (add) writes the 32-bit wrapping sum regA+regB into the destination register.
- R3: Opcode 001 (nand) writes the bitwise NOT of (regA AND regB) into the destination register, with the fields laid out as in R2.
- R4: Opcode 010 (load) loads the data-memory word at regA plus the offset into regB. The offset is in bits 15–0 as 16-bit two's complement and is sign-extended. Only the low `DMEM_AW` bits of the sum address memory.
- R5: Opcode 011 (store) writes regB to the data-memory word at regA plus the sign-extended offset. `dmem_we` is asserted only for this opcode.
- R6: Opcode 100 (branch-if-equal) sets the program counter to PC+1+offset when regA equals regB, using the sign-extended offset in bits 15–0, so backward targets work. Otherwise the program counter goes to PC+1.
- R7: Opcode 101 (jump-and-link) writes PC+1 into regB and loads the program counter from the value regA held before that write. When regA and regB are the same register, the jump uses the old value and the register ends holding PC+1.
- R8: Opcode 111 (noop) changes no register or memory. Like add, nand, load and store, it advances the program counter by exactly one.
- R9: Opcode 110 (stop) moves the controller to `ST_STOP`. From the next cycle `halted` is 1 and stays 1 until reset. The program counter stays on the stop instruction, and no register or memory write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IMEM_AW | Word address of the instruction being fetched (low bits of the PC) |
| imem_data | input | 25 | Instruction word at `imem_addr` |
| dmem_addr | output | DMEM_AW | Data-memory word address (low bits of regA+offset) |
| dmem_rdata | input | XLEN | Data word at `dmem_addr`, combinational |
| dmem_wdata | output | XLEN | Store data (regB) |
| dmem_we | output | 1 | Store enable, written at the rising edge |
| halted | output | 1 | High while the controller is in `ST_STOP` |

## Verification
In a single cycle, jump-and-link writes its link register and also reads regA to form the jump target. The bench makes these collide by loading one register with a target address and then executing jump-and-link with regA and regB naming that same register. Stores are placed at the old target and at the link address. Only the run that took the pre-write value reaches the store that records the register, and that store must record PC+1. A rival program uses distinct registers so that the ordinary link value is checked as well.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int INSTR_W = 25;
    localparam int REG_AW  = 3;
    localparam int OFF_W   = 16;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_NAND = 3'b001,
        OP_LW   = 3'b010,
        OP_SW   = 3'b011,
        OP_BEQ  = 3'b100,
        OP_JALR = 3'b101,
        OP_HALT = 3'b110,
        OP_NOOP = 3'b111
    } op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } core_state_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
        logic [REG_AW-1:0] rd;
        logic [OFF_W-1:0]  off;
    } dec_t;
endpackage

// File: rtl/wc_decode.sv
module wc_decode
    import wc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // Field positions are fixed by the instruction encoding.
    always_comb begin
        dec.op  = op_e'(instr[24:22]);
        dec.ra  = instr[21:19];
        dec.rb  = instr[18:16];
        dec.rd  = instr[2:0];
        dec.off = instr[15:0];
    end
endmodule

// File: rtl/wc_regfile.sv
module wc_regfile #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);
    localparam int NREG = 1 << REG_AW;

    logic [XLEN-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && waddr == REG_AW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/wc_alu.sv
module wc_alu
    import wc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] res,
    output logic            eq
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_NAND: res = ~(a & b);
            default: res = a + imm;
        endcase
    end

    assign eq = (a == b);
endmodule

// File: rtl/wc_seq.sv
module wc_seq
    import wc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  op_e             op,
    input  logic            eq,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] rega,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_inc,
    output logic            running,
    output logic            halted
);
    core_state_e state, state_nxt;
    logic [XLEN-1:0] pc_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:  if (op == OP_HALT) state_nxt = ST_STOP;
            ST_STOP: state_nxt = ST_STOP;
            default: state_nxt = ST_RUN;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        running = 1'b0;
        halted  = 1'b0;
        unique case (state)
            ST_RUN:  running = 1'b1;
            ST_STOP: halted  = 1'b1;
            default: running = 1'b0;
        endcase
    end

    assign pc_inc = pc + XLEN'(1);

    always_comb begin
        unique case (op)
            OP_BEQ:  pc_nxt = eq ? pc_inc + imm : pc_inc;
            OP_JALR: pc_nxt = rega;
            OP_HALT: pc_nxt = pc;
            default: pc_nxt = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          pc <= '0;
        else if (running) pc <= pc_nxt;
    end

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    assert_pc_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));
    assert_halt_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (running && op == OP_HALT) |=> (halted && pc == $past(pc)));
    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (running && (op == OP_ADD || op == OP_NAND || op == OP_LW ||
                     op == OP_SW || op == OP_NOOP))
        |=> pc == $past(pc) + XLEN'(1));
    assert_branch_R6: assert property (@(posedge clk) disable iff (rst)
        (running && op == OP_BEQ && eq) |=> pc == $past(pc) + XLEN'(1) + $past(imm));
    assert_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
        (running && op == OP_BEQ && !eq) |=> pc == $past(pc) + XLEN'(1));
    assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
        (running && op == OP_JALR) |=> pc == $past(rega));
endmodule

// File: rtl/wordcore_cpu.sv
module wordcore_cpu
    import wc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [DMEM_AW-1:0] dmem_addr,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_we,
    output logic               halted
);
    dec_t              dec;
    logic [XLEN-1:0]   imm;
    logic [XLEN-1:0]   rega, regb, alu_res;
    logic              eq;
    logic [XLEN-1:0]   pc, pc_inc;
    logic              running;
    logic              rf_we;
    logic [REG_AW-1:0] rf_wa;
    logic [XLEN-1:0]   rf_wd;

    wc_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    assign imm = {{(XLEN-OFF_W){dec.off[OFF_W-1]}}, dec.off};

    wc_regfile #(.XLEN(XLEN), .REG_AW(REG_AW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_wa),
        .wdata   (rf_wd),
        .raddr_a (dec.ra),
        .raddr_b (dec.rb),
        .rdata_a (rega),
        .rdata_b (regb)
    );

    wc_alu #(.XLEN(XLEN)) u_alu (
        .op  (dec.op),
        .a   (rega),
        .b   (regb),
        .imm (imm),
        .res (alu_res),
        .eq  (eq)
    );

    wc_seq #(.XLEN(XLEN)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .op      (dec.op),
        .eq      (eq),
        .imm     (imm),
        .rega    (rega),
        .pc      (pc),
        .pc_inc  (pc_inc),
        .running (running),
        .halted  (halted)
    );

    // Write-back selection
    always_comb begin
        rf_we = 1'b0;
        rf_wa = dec.rd;
        rf_wd = alu_res;
        if (running) begin
            unique case (dec.op)
                OP_ADD, OP_NAND: rf_we = 1'b1;
                OP_LW: begin
                    rf_we = 1'b1;
                    rf_wa = dec.rb;
                    rf_wd = dmem_rdata;
                end
                OP_JALR: begin
                    rf_we = 1'b1;
                    rf_wa = dec.rb;
                    rf_wd = pc_inc;
                end
                default: rf_we = 1'b0;
            endcase
        end
    end

    assign imem_addr  = pc[IMEM_AW-1:0];
    assign dmem_addr  = alu_res[DMEM_AW-1:0];
    assign dmem_wdata = regb;
    assign dmem_we    = running && (dec.op == OP_SW);

    assert_no_store_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_we);
    assert_store_only_sw_R5: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (dec.op == OP_SW));
    assert_no_wb_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !rf_we);
endmodule

// File: tb/wordcore_cpu_tb.sv
`timescale 1ns/1ps
module wordcore_cpu_tb;
    localparam int XLEN = 32;
    localparam int AW   = 8;
    localparam int NEXP = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   imem_addr;
    logic [24:0]     imem_data;
    logic [AW-1:0]   dmem_addr;
    logic [XLEN-1:0] dmem_rdata, dmem_wdata;
    logic            dmem_we, halted;

    logic [24:0]     imem [256];
    logic [XLEN-1:0] dmem [256];
    logic            ld_en = 1'b0;
    logic [AW-1:0]   ld_a  = '0;
    logic [XLEN-1:0] ld_d  = '0;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wordcore_cpu #(.XLEN(XLEN), .IMEM_AW(AW), .DMEM_AW(AW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .halted     (halted)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (ld_en)        dmem[ld_a] <= ld_d;
        else if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    function automatic logic [24:0] enc_i(input logic [2:0] op, input logic [2:0] a,
                                          input logic [2:0] b, input int off);
        return {op, a, b, 16'(off)};
    endfunction

    function automatic logic [24:0] enc_r(input logic [2:0] op, input logic [2:0] a,
                                          input logic [2:0] b, input logic [2:0] d);
        return {op, a, b, 13'd0, d};
    endfunction

    function automatic logic [XLEN-1:0] init_val(input int a);
        case (a)
            100:     return 32'd7;
            101:     return 32'hFFFF_FFFF;
            102:     return 32'h1234_5678;
            103:     return 32'd200;
            104:     return 32'd28;
            105:     return 32'd33;
            119:     return 32'hDEAD_BEEF;
            default: return 32'd0;
        endcase
    endfunction

    // {address, expected word, requirement number}
    localparam logic [43:0] EXP [NEXP] = '{
        {8'd110, 32'h0000_0006, 4'd2},  // R2 add wraps 7 + 0xFFFFFFFF
        {8'd111, 32'hFFFF_FFF8, 4'd3},  // R3 nand
        {8'd112, 32'h1234_5678, 4'd4},  // R4 load with negative offset
        {8'd113, 32'h0000_0000, 4'd6},  // R6 taken branch skipped a store
        {8'd114, 32'hFFFF_FFFF, 4'd6},  // R6 not-taken branch fell through
        {8'd115, 32'h0000_0007, 4'd6},  // R6 backward branch target
        {8'd116, 32'd26,        4'd7},  // R7 link value PC+1
        {8'd117, 32'd31,        4'd7},  // R7 same-register link/jump
        {8'd118, 32'h0000_0007, 4'd8},  // R8 noop left registers alone
        {8'd119, 32'h0000_0000, 4'd1},  // R1 r0 reads zero after reset, R5 overwrite
        {8'd120, 32'h1234_5678, 4'd4},  // R4 high address bits ignored
        {8'd121, 32'h0000_0000, 4'd9}   // R9 nothing after stop
    };

    task automatic chk(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_stop(input string tag);
        int cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(tag, {31'd0, halted}, 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) imem[i] = {3'b110, 22'd0};
        imem[0]  = enc_i(3'b010, 0, 1, 100);
        imem[1]  = enc_i(3'b010, 0, 2, 101);
        imem[2]  = enc_r(3'b000, 1, 2, 3);
        imem[3]  = enc_r(3'b001, 1, 2, 4);
        imem[4]  = enc_i(3'b010, 0, 6, 103);
        imem[5]  = enc_i(3'b010, 6, 5, -98);
        imem[6]  = enc_i(3'b011, 0, 3, 110);
        imem[7]  = enc_i(3'b011, 0, 4, 111);
        imem[8]  = enc_i(3'b011, 0, 5, 112);
        imem[9]  = enc_i(3'b100, 1, 1, 2);
        imem[10] = enc_i(3'b011, 0, 1, 113);
        imem[12] = enc_i(3'b100, 1, 2, 5);
        imem[13] = enc_i(3'b011, 0, 2, 114);
        imem[14] = {3'b111, 22'd0};
        imem[15] = enc_i(3'b100, 0, 0, 2);
        imem[18] = enc_i(3'b100, 0, 0, 3);
        imem[20] = enc_i(3'b011, 0, 1, 115);
        imem[21] = enc_i(3'b100, 0, 0, 2);
        imem[22] = enc_i(3'b100, 0, 0, -3);
        imem[24] = enc_i(3'b010, 0, 7, 104);
        imem[25] = enc_r(3'b101, 7, 6, 0);
        imem[28] = enc_i(3'b011, 0, 6, 116);
        imem[29] = enc_i(3'b010, 0, 7, 105);
        imem[30] = enc_r(3'b101, 7, 7, 0);
        imem[33] = enc_i(3'b011, 0, 7, 117);
        imem[34] = {3'b111, 22'd0};
        imem[35] = enc_i(3'b011, 0, 1, 118);
        imem[36] = enc_i(3'b011, 0, 0, 119);
        imem[37] = enc_i(3'b010, 0, 1, -154);
        imem[38] = enc_i(3'b011, 0, 1, 120);
        imem[39] = {3'b110, 22'd0};
        imem[40] = enc_i(3'b011, 0, 2, 121);

        // Preload data memory while the core is held in reset.
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_a  = AW'(a);
            ld_d  = init_val(a);
        end
        @(negedge clk);
        ld_en = 1'b0;

        // R1: reset state
        chk("R1 halted in reset", {31'd0, halted}, 32'd0);
        chk("R1 pc in reset", {24'd0, imem_addr}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        wait_stop("R9 halted rises");
        chk("R9 pc on stop", {24'd0, imem_addr}, 32'd39);
        repeat (5) @(negedge clk);
        chk("R9 halted sticky", {31'd0, halted}, 32'd1);
        chk("R9 pc frozen", {24'd0, imem_addr}, 32'd39);

        for (int i = 0; i < NEXP; i++) begin
            chk($sformatf("R%0d mem[%0d]", EXP[i][3:0], EXP[i][43:36]),
                dmem[EXP[i][43:36]], EXP[i][35:4]);
        end
        chk("R5 store source", dmem[110], 32'd6);

        // R1: reset leaves the stopped state
        rst = 1'b1;
        @(negedge clk);
        chk("R1 halted cleared", {31'd0, halted}, 32'd0);
        chk("R1 pc cleared", {24'd0, imem_addr}, 32'd0);
        rst = 1'b0;
        wait_stop("R9 second run stops");
        chk("R9 second run pc", {24'd0, imem_addr}, 32'd39);
        chk("R7 second run link", dmem[117], 32'd31);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule